// File: doc/BRIEF.md
# MSI Snooping Coherence Controller

This block keeps a small group of private caches coherent over one shared snooping bus. Every cache holds a slot for each line address, and every slot is in one of three states: Modified, Shared or Invalid. Each cache presents one request at a time: a read, a write or an eviction of a whole line. The controller serialises these requests through a round-robin grant and decides whether each one can complete locally or needs a bus transaction. For a bus transaction it broadcasts a read, a read-exclusive or a write-back and then updates the state of that line in every cache in the same step.

The data stores are tiny register files. These are one data word per line per cache, plus a backing memory array with one word per line address. A request is accepted in the cycle after it is raised. It completes in the following cycle with a one-cycle response pulse, and the bus signals are valid in that same cycle. The coherence state of every slot is brought out on a flat status vector so that the surrounding logic can observe the protocol.

Top module: `msi_coherence_ctrl`

## Requirements
- R1: After reset every slot is Invalid (state code 0), no response or bus transaction is active, and backing memory line `a` holds `(a*37+11) mod 2^DATA_W`.
- R2: Whenever a line is Modified (code 2) in one cache, no other cache holds that line as Shared (code 1) or Modified.
- R3: A read (op 0, and the reserved op 3) of an Invalid slot issues a bus read (command 1) when no other cache holds the line Modified. It returns the memory word and leaves the requester Shared.
- R4: A read of an Invalid slot while another cache holds the line Modified issues a bus read. The owner supplies its word, that word is written back to memory, the owner drops to Shared and the requester ends Shared with that word.
- R5: A write (op 1) to a Shared or Invalid slot issues a bus read-exclusive (command 2). Every other copy becomes Invalid and the requester becomes Modified and holds the written word.
- R6: A read that hits Shared or Modified, and a write that hits Modified, complete with the bus idle (busValid low, command 0) and leave all states unchanged, except that the write updates the word.
- R7: An eviction (op 2) of a Modified slot issues a write-back (command 3) that stores the word to memory. An eviction of a Shared or Invalid slot uses no bus. Either way the slot ends Invalid.
- R8: Grants rotate round-robin, starting the search after the last granted cache (cache 0 first after reset). One request is handled at a time. A request raised while the controller is idle is answered by a response pulse exactly two rising edges later, and the bus owner and address lines then name the requester and its line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | NUM_CACHES | Per-cache request pending; held until that cache's response |
| reqOp | input | 2*NUM_CACHES | Per-cache opcode: 0 read, 1 write, 2 evict, 3 read |
| reqAddr | input | ADDR_W*NUM_CACHES | Per-cache line address |
| reqWData | input | DATA_W*NUM_CACHES | Per-cache write word |
| respValid | output | NUM_CACHES | One-cycle completion pulse to the served cache |
| respData | output | DATA_W | Line word returned for a read |
| busValid | output | 1 | A bus transaction is broadcast this cycle |
| busCmd | output | 2 | 0 none, 1 read, 2 read-exclusive, 3 write-back |
| busOwner | output | clog2(NUM_CACHES) | Cache that owns the current transaction |
| busAddr | output | ADDR_W | Line address of the current transaction |
| lineState | output | 2*NUM_CACHES*2^ADDR_W | State of slot (cache c, line a) at bits [(c*2^ADDR_W+a)*2 +: 2] |

## Verification
The bench chains the sharp transitions on one line. A write steals a line from several sharers. A read then pulls the word from the Modified owner, and a later miss must see that word in memory. A design that skips the owner's write-back returns stale data on that later miss. A design that forgets to invalidate the sharers leaves two live copies, which the exclusivity check catches. Hits in Shared or Modified must not touch the bus, so a design that always broadcasts shows a nonzero command. Simultaneous requests test that the grant order rotates and does not favour low indices, and a long random run compares every state and returned word against a reference model.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    LINE_I = 2'd0,
    LINE_S = 2'd1,
    LINE_M = 2'd2
  } lineSt_e;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_EV  = 2'd2,
    OP_RSV = 2'd3
  } reqOp_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_RDX  = 2'd2,
    CMD_WB   = 2'd3
  } busCmd_e;

  // Strobes from the control to the datapath for the transaction being executed
  typedef struct packed {
    logic fill;        // requester loads the line and goes Shared
    logic fromPeer;    // fill word comes from the Modified peer instead of memory
    logic demotePeer;  // Modified peer drops to Shared
    logic wbPeer;      // Modified peer word is copied to memory
    logic writeLine;   // requester stores write word and goes Modified
    logic invOthers;   // all other copies go Invalid
    logic wbSelf;      // requester word is copied to memory
    logic dropSelf;    // requester slot goes Invalid
  } dpStrobe_t;

endpackage

// File: rtl/msi_ctrl.sv
module msi_ctrl
  import msi_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_CACHES-1:0]        reqValid,
  input  logic [2*NUM_CACHES-1:0]      reqOp,
  input  logic [ADDR_W*NUM_CACHES-1:0] reqAddr,
  input  logic [DATA_W*NUM_CACHES-1:0] reqWData,
  input  lineSt_e                      curState,
  input  logic                         peerHasM,
  output logic [((NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1)-1:0] curIdx,
  output logic [ADDR_W-1:0]            curAddr,
  output logic [DATA_W-1:0]            curWData,
  output dpStrobe_t                    stb,
  output logic [NUM_CACHES-1:0]        respValid,
  output logic                         busValid,
  output busCmd_e                      busCmd
);

  localparam int IDX_W = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1;

  typedef enum logic {PH_IDLE = 1'b0, PH_EXEC = 1'b1} phase_e;

  phase_e           phase;
  reqOp_e           curOp;
  logic [IDX_W-1:0] lastGrant;
  logic [IDX_W-1:0] pickIdx;
  logic             pickValid;

  // Round-robin search beginning after the last granted cache
  always_comb begin
    pickValid = 1'b0;
    pickIdx   = '0;
    for (int k = 1; k <= NUM_CACHES; k++) begin
      int cand;
      cand = (int'(lastGrant) + k) % NUM_CACHES;
      if (!pickValid && reqValid[cand]) begin
        pickValid = 1'b1;
        pickIdx   = IDX_W'(cand);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      lastGrant <= IDX_W'(NUM_CACHES - 1);
      curIdx    <= '0;
      curOp     <= OP_RD;
      curAddr   <= '0;
      curWData  <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (pickValid) begin
            phase     <= PH_EXEC;
            lastGrant <= pickIdx;
            curIdx    <= pickIdx;
            curOp     <= reqOp_e'(reqOp[int'(pickIdx)*2 +: 2]);
            curAddr   <= reqAddr[int'(pickIdx)*ADDR_W +: ADDR_W];
            curWData  <= reqWData[int'(pickIdx)*DATA_W +: DATA_W];
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // Execute-cycle decode: local completion or bus transaction
  always_comb begin
    stb       = '0;
    respValid = '0;
    busValid  = 1'b0;
    busCmd    = CMD_NONE;
    if (phase == PH_EXEC) begin
      respValid[curIdx] = 1'b1;
      case (curOp)
        OP_WR: begin
          stb.writeLine = 1'b1;
          if (curState != LINE_M) begin
            stb.invOthers = 1'b1;
            busValid      = 1'b1;
            busCmd        = CMD_RDX;
          end
        end
        OP_EV: begin
          stb.dropSelf = 1'b1;
          if (curState == LINE_M) begin
            stb.wbSelf = 1'b1;
            busValid   = 1'b1;
            busCmd     = CMD_WB;
          end
        end
        default: begin
          if (curState == LINE_I) begin
            stb.fill       = 1'b1;
            stb.fromPeer   = peerHasM;
            stb.demotePeer = peerHasM;
            stb.wbPeer     = peerHasM;
            busValid       = 1'b1;
            busCmd         = CMD_RD;
          end
        end
      endcase
    end
  end

  // R8: a transaction occupies exactly one execute cycle
  a_r8_exec_single: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_EXEC |=> phase == PH_IDLE);

  // R8: an idle controller with a pending request grants on the next edge
  a_r8_idle_grants: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && |reqValid) |=> phase == PH_EXEC);

  // R8: at most one cache is answered per cycle
  a_r8_one_resp: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(respValid));

  // R6: read hits leave the bus quiet
  a_r6_hit_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_EXEC && (curOp == OP_RD || curOp == OP_RSV) && curState != LINE_I)
      |-> !busValid);

endmodule

// File: rtl/msi_dpath.sv
module msi_dpath
  import msi_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpStrobe_t                    stb,
  input  logic [((NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1)-1:0] curIdx,
  input  logic [ADDR_W-1:0]            curAddr,
  input  logic [DATA_W-1:0]            curWData,
  output lineSt_e                      curState,
  output logic                         peerHasM,
  output logic [DATA_W-1:0]            respData,
  output logic [NUM_CACHES*(2**ADDR_W)*2-1:0] lineStateFlat
);

  localparam int LINES = 2 ** ADDR_W;
  localparam int IDX_W = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1;

  lineSt_e           stArr   [NUM_CACHES][LINES];
  logic [DATA_W-1:0] dataArr [NUM_CACHES][LINES];
  logic [DATA_W-1:0] memArr  [LINES];

  logic [IDX_W-1:0]  peerIdx;
  logic [DATA_W-1:0] peerData;
  logic [DATA_W-1:0] fillData;

  function automatic logic [DATA_W-1:0] memInit(int a);
    return DATA_W'(a * 37 + 11);
  endfunction

  // Snoop: find a Modified copy in another cache
  always_comb begin
    peerHasM = 1'b0;
    peerIdx  = '0;
    for (int k = 0; k < NUM_CACHES; k++) begin
      if (k != int'(curIdx) && stArr[k][curAddr] == LINE_M) begin
        peerHasM = 1'b1;
        peerIdx  = IDX_W'(k);
      end
    end
  end

  assign curState = stArr[curIdx][curAddr];
  assign peerData = dataArr[peerIdx][curAddr];
  assign fillData = stb.fromPeer ? peerData : memArr[curAddr];
  assign respData = (curState != LINE_I) ? dataArr[curIdx][curAddr]
                  : (peerHasM ? peerData : memArr[curAddr]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CACHES; c++) begin
        for (int a = 0; a < LINES; a++) begin
          stArr[c][a]   <= LINE_I;
          dataArr[c][a] <= '0;
        end
      end
      for (int a = 0; a < LINES; a++) memArr[a] <= memInit(a);
    end else begin
      if (stb.fill) begin
        dataArr[curIdx][curAddr] <= fillData;
        stArr[curIdx][curAddr]   <= LINE_S;
      end
      if (stb.demotePeer) stArr[peerIdx][curAddr] <= LINE_S;
      if (stb.wbPeer)     memArr[curAddr] <= peerData;
      if (stb.invOthers) begin
        for (int k = 0; k < NUM_CACHES; k++) begin
          if (k != int'(curIdx)) stArr[k][curAddr] <= LINE_I;
        end
      end
      if (stb.writeLine) begin
        dataArr[curIdx][curAddr] <= curWData;
        stArr[curIdx][curAddr]   <= LINE_M;
      end
      if (stb.wbSelf)   memArr[curAddr] <= dataArr[curIdx][curAddr];
      if (stb.dropSelf) stArr[curIdx][curAddr] <= LINE_I;
    end
  end

  // Per-line holder vectors for the exclusivity checks
  logic [NUM_CACHES-1:0] holdVec [LINES];
  logic [NUM_CACHES-1:0] modVec  [LINES];

  always_comb begin
    for (int a = 0; a < LINES; a++) begin
      for (int c = 0; c < NUM_CACHES; c++) begin
        holdVec[a][c] = (stArr[c][a] != LINE_I);
        modVec[a][c]  = (stArr[c][a] == LINE_M);
      end
    end
  end

  for (genvar c = 0; c < NUM_CACHES; c++) begin : g_cache
    for (genvar a = 0; a < LINES; a++) begin : g_line
      assign lineStateFlat[(c*LINES+a)*2 +: 2] = stArr[c][a];

      // R7: an evicted slot is Invalid afterwards
      a_r7_evict_invalid: assert property (@(posedge clk) disable iff (!rstN)
        (stb.dropSelf && int'(curIdx) == c && int'(curAddr) == a)
          |=> stArr[c][a] == LINE_I);
    end
  end

  for (genvar a = 0; a < LINES; a++) begin : g_excl
    // R2: a Modified copy is the only copy
    a_r2_m_exclusive: assert property (@(posedge clk) disable iff (!rstN)
      (|modVec[a]) |-> $countones(holdVec[a]) == 1);

    // R5: after a read-exclusive exactly one Modified holder remains
    a_r5_rdx_sole: assert property (@(posedge clk) disable iff (!rstN)
      (stb.invOthers && int'(curAddr) == a)
        |=> ($countones(holdVec[a]) == 1 && $countones(modVec[a]) == 1));
  end

endmodule

// File: rtl/msi_coherence_ctrl.sv
module msi_coherence_ctrl
  import msi_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_CACHES-1:0]        reqValid,
  input  logic [2*NUM_CACHES-1:0]      reqOp,
  input  logic [ADDR_W*NUM_CACHES-1:0] reqAddr,
  input  logic [DATA_W*NUM_CACHES-1:0] reqWData,
  output logic [NUM_CACHES-1:0]        respValid,
  output logic [DATA_W-1:0]            respData,
  output logic                         busValid,
  output logic [1:0]                   busCmd,
  output logic [((NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1)-1:0] busOwner,
  output logic [ADDR_W-1:0]            busAddr,
  output logic [NUM_CACHES*(2**ADDR_W)*2-1:0] lineState
);

  localparam int IDX_W = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1;

  dpStrobe_t         stb;
  lineSt_e           curState;
  logic              peerHasM;
  logic [IDX_W-1:0]  curIdx;
  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] curWData;
  busCmd_e           cmdSel;

  msi_ctrl #(.NUM_CACHES(NUM_CACHES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr), .reqWData(reqWData),
    .curState(curState), .peerHasM(peerHasM),
    .curIdx(curIdx), .curAddr(curAddr), .curWData(curWData),
    .stb(stb), .respValid(respValid), .busValid(busValid), .busCmd(cmdSel)
  );

  msi_dpath #(.NUM_CACHES(NUM_CACHES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .curIdx(curIdx), .curAddr(curAddr), .curWData(curWData),
    .curState(curState), .peerHasM(peerHasM), .respData(respData),
    .lineStateFlat(lineState)
  );

  assign busCmd   = cmdSel;
  assign busOwner = curIdx;
  assign busAddr  = curAddr;

endmodule

// File: tb/msi_coherence_ctrl_tb.sv
`timescale 1ns/1ps
module msi_coherence_ctrl_tb;

  localparam int NC = 4;
  localparam int AW = 2;
  localparam int DW = 8;
  localparam int NL = 1 << AW;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NC-1:0]     reqValid = '0;
  logic [2*NC-1:0]   reqOp = '0;
  logic [AW*NC-1:0]  reqAddr = '0;
  logic [DW*NC-1:0]  reqWData = '0;
  logic [NC-1:0]     respValid;
  logic [DW-1:0]     respData;
  logic              busValid;
  logic [1:0]        busCmd;
  logic [1:0]        busOwner;
  logic [AW-1:0]     busAddr;
  logic [NC*NL*2-1:0] lineState;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int mSt   [NC][NL];
  int mData [NC][NL];
  int mMem  [NL];
  int mLast = NC - 1;

  always #4 clk = ~clk;

  msi_coherence_ctrl #(.NUM_CACHES(NC), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqWData(reqWData), .respValid(respValid), .respData(respData),
    .busValid(busValid), .busCmd(busCmd), .busOwner(busOwner), .busAddr(busAddr),
    .lineState(lineState)
  );

  function automatic int memInitRef(int a);
    return (a * 37 + 11) % 256;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare all slot states to the model, plus the exclusivity rule (R2)
  task automatic checkStates(string req);
    bit allOk = 1;
    int bad = 0;
    for (int c = 0; c < NC; c++)
      for (int a = 0; a < NL; a++)
        if (int'(lineState[(c*NL+a)*2 +: 2]) != mSt[c][a]) begin
          allOk = 0;
          bad = int'(lineState[(c*NL+a)*2 +: 2]);
        end
    chk(allOk, req, bad, 0);
    for (int a = 0; a < NL; a++) begin
      int holders = 0;
      int mods = 0;
      for (int c = 0; c < NC; c++) begin
        if (lineState[(c*NL+a)*2 +: 2] != 2'd0) holders++;
        if (lineState[(c*NL+a)*2 +: 2] == 2'd2) mods++;
      end
      chk(!(mods > 0 && holders != 1), "R2 modified copy exclusive", holders, 1);
    end
  endtask

  // One request on one cache; expectation computed from the model first
  task automatic doOp(int c, int op, int a, int wd);
    int curS = mSt[c][a];
    int peer = -1;
    int expBus = 0;
    int expCmd = 0;
    int expData = 0;
    string tag;
    int waits = 0;
    for (int k = 0; k < NC; k++) if (k != c && mSt[k][a] == 2) peer = k;
    if (op == 0 || op == 3) begin
      if (curS != 0) begin
        tag = "R6 read hit"; expData = mData[c][a];
      end else begin
        expBus = 1; expCmd = 1;
        if (peer >= 0) begin
          tag = "R4 read from owner";
          expData = mData[peer][a];
          mMem[a] = expData;
          mSt[peer][a] = 1;
        end else begin
          tag = "R3 read from memory";
          expData = mMem[a];
        end
        mData[c][a] = expData;
        mSt[c][a] = 1;
      end
    end else if (op == 1) begin
      if (curS == 2) tag = "R6 write hit";
      else begin
        tag = "R5 read-exclusive"; expBus = 1; expCmd = 2;
        for (int k = 0; k < NC; k++) if (k != c) mSt[k][a] = 0;
      end
      mData[c][a] = wd;
      mSt[c][a] = 2;
    end else begin
      if (curS == 2) begin
        tag = "R7 evict write-back"; expBus = 1; expCmd = 3;
        mMem[a] = mData[c][a];
      end else tag = "R7 evict clean";
      mSt[c][a] = 0;
    end
    mLast = c;

    reqOp[c*2 +: 2]     = 2'(op);
    reqAddr[c*AW +: AW] = AW'(a);
    reqWData[c*DW +: DW] = DW'(wd);
    reqValid[c] = 1'b1;
    do begin
      @(negedge clk);
      waits++;
    end while (!respValid[c] && waits < 20);
    chk(waits == 1, "R8 response two edges after request", waits, 1);
    chk(busValid == 1'(expBus), tag, int'(busValid), expBus);
    chk(int'(busCmd) == expCmd, tag, int'(busCmd), expCmd);
    if (expBus == 1) begin
      chk(int'(busOwner) == c, "R8 bus owner", int'(busOwner), c);
      chk(int'(busAddr) == a, "R8 bus address", int'(busAddr), a);
    end
    if (op == 0 || op == 3) chk(int'(respData) == expData, tag, int'(respData), expData);
    reqValid[c] = 1'b0;
    @(negedge clk);
    checkStates(tag);
  endtask

  // Several caches request together; grants must follow round-robin order
  task automatic rrBurst(logic [NC-1:0] mask);
    logic [NC-1:0] pend = mask;
    int expOrder [NC];
    int nExp = 0;
    int ptr = mLast;
    int waits = 0;
    for (int k = 1; k <= NC; k++) begin
      int cand = (ptr + k) % NC;
      if (mask[cand]) begin expOrder[nExp] = cand; nExp++; end
    end
    for (int c = 0; c < NC; c++) if (mask[c]) begin
      reqOp[c*2 +: 2] = 2'd2;      // evict of an Invalid line: no state change
      reqAddr[c*AW +: AW] = AW'(NL - 1);
    end
    reqValid = mask;
    for (int n = 0; n < nExp; n++) begin
      int got = -1;
      waits = 0;
      do begin
        @(negedge clk);
        waits++;
      end while (respValid == '0 && waits < 20);
      for (int c = 0; c < NC; c++) if (respValid[c]) got = c;
      chk(got == expOrder[n], "R8 round-robin order", got, expOrder[n]);
      if (got >= 0) begin reqValid[got] = 1'b0; pend[got] = 1'b0; mLast = got; end
    end
    reqValid = '0;
    @(negedge clk);
    checkStates("R8 burst leaves states");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int c = 0; c < NC; c++) for (int a = 0; a < NL; a++) begin
      mSt[c][a] = 0; mData[c][a] = 0;
    end
    for (int a = 0; a < NL; a++) mMem[a] = memInitRef(a);

    repeat (3) @(negedge clk);
    chk(lineState == '0, "R1 reset states Invalid", int'(lineState != '0), 0);
    chk(respValid == '0, "R1 reset no response", int'(respValid), 0);
    chk(busValid == 1'b0, "R1 reset bus idle", int'(busValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 memory pattern seen through first misses; R3 plain miss
    doOp(0, 0, 1, 0);
    doOp(2, 3, 0, 0);
    doOp(0, 0, 1, 0);                // R6 read hit in Shared
    // R5 write steals from sharers
    doOp(3, 0, 1, 0);
    doOp(1, 1, 1, 8'h5A);
    // R4 owner supplies and writes back
    doOp(2, 0, 1, 0);
    doOp(1, 2, 1, 0);                // R7 clean evict of Shared
    doOp(2, 2, 1, 0);
    doOp(3, 0, 1, 0);                // later miss reads written-back word
    // R6 write hit, R7 dirty evict
    doOp(0, 1, 2, 8'h11);
    doOp(0, 1, 2, 8'h22);
    doOp(0, 0, 2, 0);
    doOp(0, 2, 2, 0);
    doOp(3, 0, 2, 0);
    doOp(3, 0, 2, 0);
    // R8 arbitration
    rrBurst(4'b1111);
    rrBurst(4'b1100);
    rrBurst(4'b0101);
    rrBurst(4'b1011);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int c = int'($urandom % NC);
      int a = int'($urandom % (NL - 1));
      int r = int'($urandom % 10);
      int op = (r < 5) ? 0 : ((r < 8) ? 1 : 2);
      doOp(c, op, a, int'($urandom % 256));
      if (i % 50 == 49) rrBurst(NC'($urandom % (1 << NC)));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule